// File: doc/BRIEF.md
# Majority-Vote Branch History Predictor

This block guesses the direction of conditional branches from the recent behaviour of each branch. It keeps a direct-mapped table of short outcome shift registers. A slice of the program counter selects the entry. Every resolved branch pushes its actual outcome into its entry as the newest bit, and the oldest bit falls off the far end. The fetch stage presents a PC on the lookup side and gets back, in the same cycle, the stored history for that slot and a taken / not-taken guess. The guess is a majority vote over the history bits.

The history length, the number of index bits, the number of instruction alignment bits and an optional line-sharing shift are all parameters. With the line shift at zero, each aligned instruction address gets its own slot. With the line shift set to k, all instructions inside a block of 2^k aligned words share one slot, which gives one history per cache line. The table has no tags, so PCs that differ only above the index slice alias onto the same entry.

The lookup path is purely combinational from the lookup PC and the table registers. An update in a given cycle therefore becomes visible to lookups only from the next cycle on.

Top module: `mvbp_predictor`

## Requirements
- R1: After a synchronous active-high reset, every entry holds all zeros, so every lookup returns a history of 0 and a not-taken guess.
- R2: `lk_hist` shows the stored history of the entry selected by `lk_pc`. Bit 0 is the newest outcome and bit HIST_W-1 is the oldest.
- R3: An outcome bit of 1 means taken and 0 means not taken, both on `up_taken` and in every history bit. `lk_taken` is 1 for a taken guess.
- R4: `lk_taken` is 1 exactly when more than half of the HIST_W history bits are 1. With the default of three bits, two or three ones predict taken and zero or one predict not taken.
- R5: When HIST_W is even and exactly half the bits are 1, the guess is not taken.
- R6: When `up_valid` is 1 at a rising clock edge, the selected entry becomes its old value shifted left by one, with `up_taken` in bit 0 and the old bit HIST_W-1 discarded. No other entry changes.
- R7: The entry index is `pc[ALIGN_W+LINE_W +: IDX_W]`. The alignment bits, the line-offset bits and all bits above the index are ignored, so PCs that agree on the index slice share an entry.
- R8: With LINE_W > 0, all instructions of one 2^LINE_W-word line share one history, and an update from any of them is seen by a lookup from any other.
- R9: A lookup and an update to the same entry in one cycle: the lookup returns the value from before the update, and the updated value appears from the next cycle.
- R10: When `up_valid` is 0, no entry changes, whatever `up_pc` and `up_taken` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, clears all histories |
| lk_pc | input | PC_W | Fetch-side lookup address |
| lk_taken | output | 1 | Guess for the branch at `lk_pc`: 1 taken, 0 not taken |
| lk_hist | output | HIST_W | Stored outcome history for `lk_pc`, bit 0 newest |
| up_valid | input | 1 | Qualifies an update in this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome: 1 taken, 0 not taken |

## Verification
The clocked properties assume that `lk_pc`, `up_pc`, `up_valid` and `up_taken` are known, stable values at every rising edge outside reset. They also assume that the reset is held for at least one edge before any update matters. The bench changes every input only on the falling edge, holds reset across several edges first, and never leaves an input undriven. The history-shift property checks an entry only when the lookup index stays the same for two cycles. The directed sequences therefore hold the lookup PC on the updated branch while its history is built up, and the mixed phase mainly exercises the scoreboard.

// File: rtl/mvbp_pkg.sv
package mvbp_pkg;

    // Default configuration of the predictor.
    localparam int DEF_PC_W    = 32;
    localparam int DEF_IDX_W   = 4;
    localparam int DEF_ALIGN_W = 2;
    localparam int DEF_LINE_W  = 0;
    localparam int DEF_HIST_W  = 3;

    // Encoding of a branch outcome bit.
    typedef enum logic {
        OUT_NOT_TAKEN = 1'b0,
        OUT_TAKEN     = 1'b1
    } outcome_e;

    // Lowest PC bit that feeds the entry index.
    function automatic int index_lsb(int align_w, int line_w);
        return align_w + line_w;
    endfunction

    // Number of set history bits needed for a taken guess: strict majority.
    // Even lengths therefore resolve a tie to not taken.
    function automatic int votes_needed(int hist_w);
        return (hist_w / 2) + 1;
    endfunction

endpackage

// File: rtl/mvbp_index.sv
module mvbp_index #(
    parameter int PC_W    = mvbp_pkg::DEF_PC_W,
    parameter int IDX_W   = mvbp_pkg::DEF_IDX_W,
    parameter int ALIGN_W = mvbp_pkg::DEF_ALIGN_W,
    parameter int LINE_W  = mvbp_pkg::DEF_LINE_W
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    localparam int LSB = mvbp_pkg::index_lsb(ALIGN_W, LINE_W);

    // Slice the index out of the PC; everything else is dropped.
    assign idx = pc[LSB +: IDX_W];

    logic unused_pc_parity;
    assign unused_pc_parity = ^pc;

endmodule

// File: rtl/mvbp_vote.sv
module mvbp_vote #(
    parameter int HIST_W = mvbp_pkg::DEF_HIST_W
) (
    input  logic [HIST_W-1:0] hist,
    output mvbp_pkg::outcome_e guess
);
    localparam int CNT_W  = $clog2(HIST_W + 1);
    localparam int NEEDED = mvbp_pkg::votes_needed(HIST_W);

    logic [CNT_W-1:0] ones;

    always_comb begin
        ones = '0;
        for (int b = 0; b < HIST_W; b++) begin
            ones = ones + CNT_W'(hist[b]);
        end
    end

    assign guess = (int'(ones) >= NEEDED) ? mvbp_pkg::OUT_TAKEN
                                          : mvbp_pkg::OUT_NOT_TAKEN;

endmodule

// File: rtl/mvbp_hist_table.sv
module mvbp_hist_table #(
    parameter int IDX_W  = mvbp_pkg::DEF_IDX_W,
    parameter int HIST_W = mvbp_pkg::DEF_HIST_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  mvbp_pkg::outcome_e wr_bit,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [HIST_W-1:0]  rd_hist
);
    localparam int DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0] hist_q [DEPTH];
    logic [HIST_W-1:0] wr_cur;
    logic [HIST_W-1:0] wr_next;

    assign wr_cur = hist_q[wr_idx];

    // Shift the resolved outcome in at bit 0; the oldest bit falls off.
    generate
        if (HIST_W == 1) begin : g_single
            logic unused_cur;
            assign unused_cur = wr_cur[0];
            assign wr_next = wr_bit;
        end else begin : g_shift
            logic unused_oldest;
            assign unused_oldest = wr_cur[HIST_W-1];
            assign wr_next = {wr_cur[HIST_W-2:0], wr_bit};
        end
    endgenerate

    generate
        for (genvar e = 0; e < DEPTH; e++) begin : g_entry
            always_ff @(posedge clk) begin
                if (rst) begin
                    hist_q[e] <= '0;
                end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                    hist_q[e] <= wr_next;
                end
            end
        end
    endgenerate

    // Read is combinational: same-cycle updates are seen one cycle later.
    assign rd_hist = hist_q[rd_idx];

endmodule

// File: rtl/mvbp_predictor.sv
module mvbp_predictor #(
    parameter int PC_W    = mvbp_pkg::DEF_PC_W,
    parameter int IDX_W   = mvbp_pkg::DEF_IDX_W,
    parameter int ALIGN_W = mvbp_pkg::DEF_ALIGN_W,
    parameter int LINE_W  = mvbp_pkg::DEF_LINE_W,
    parameter int HIST_W  = mvbp_pkg::DEF_HIST_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PC_W-1:0]   lk_pc,
    output logic              lk_taken,
    output logic [HIST_W-1:0] lk_hist,
    input  logic              up_valid,
    input  logic [PC_W-1:0]   up_pc,
    input  logic              up_taken
);
    logic [IDX_W-1:0]   lk_idx;
    logic [IDX_W-1:0]   up_idx;
    mvbp_pkg::outcome_e up_outcome;
    mvbp_pkg::outcome_e guess;

    assign up_outcome = up_taken ? mvbp_pkg::OUT_TAKEN : mvbp_pkg::OUT_NOT_TAKEN;

    mvbp_index #(
        .PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W), .LINE_W(LINE_W)
    ) u_lk_index (
        .pc  (lk_pc),
        .idx (lk_idx)
    );

    mvbp_index #(
        .PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W), .LINE_W(LINE_W)
    ) u_up_index (
        .pc  (up_pc),
        .idx (up_idx)
    );

    mvbp_hist_table #(
        .IDX_W(IDX_W), .HIST_W(HIST_W)
    ) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (up_valid),
        .wr_idx  (up_idx),
        .wr_bit  (up_outcome),
        .rd_idx  (lk_idx),
        .rd_hist (lk_hist)
    );

    mvbp_vote #(
        .HIST_W(HIST_W)
    ) u_vote (
        .hist  (lk_hist),
        .guess (guess)
    );

    assign lk_taken = (guess == mvbp_pkg::OUT_TAKEN);

endmodule

// File: rtl/mvbp_checker.sv
module mvbp_checker #(
    parameter int PC_W    = mvbp_pkg::DEF_PC_W,
    parameter int IDX_W   = mvbp_pkg::DEF_IDX_W,
    parameter int ALIGN_W = mvbp_pkg::DEF_ALIGN_W,
    parameter int LINE_W  = mvbp_pkg::DEF_LINE_W,
    parameter int HIST_W  = mvbp_pkg::DEF_HIST_W
) (
    input logic              clk,
    input logic              rst,
    input logic [PC_W-1:0]   lk_pc,
    input logic              lk_taken,
    input logic [HIST_W-1:0] lk_hist,
    input logic              up_valid,
    input logic [PC_W-1:0]   up_pc,
    input logic              up_taken
);
    localparam int LSB = mvbp_pkg::index_lsb(ALIGN_W, LINE_W);

    logic [IDX_W-1:0] c_lk_idx;
    logic [IDX_W-1:0] c_up_idx;
    assign c_lk_idx = lk_pc[LSB +: IDX_W];
    assign c_up_idx = up_pc[LSB +: IDX_W];

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lk_hist == '0) && !lk_taken); // R1

    AST_ALL_TAKEN_VOTE: assert property (@(posedge clk) disable iff (rst)
        ($countones(lk_hist) == HIST_W) |-> lk_taken); // R4

    AST_NONE_TAKEN_VOTE: assert property (@(posedge clk) disable iff (rst)
        (lk_hist == '0) |-> !lk_taken); // R3

    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(up_valid) && ($past(c_up_idx) == c_lk_idx)
         && ($past(c_lk_idx) == c_lk_idx))
        |-> (lk_hist[0] == $past(up_taken))); // R6

    AST_HOLD_NO_UPDATE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(c_lk_idx) == c_lk_idx)
         && (!$past(up_valid) || ($past(c_up_idx) != c_lk_idx)))
        |-> (lk_hist == $past(lk_hist))); // R10

endmodule

bind mvbp_predictor mvbp_checker #(
    .PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W), .LINE_W(LINE_W), .HIST_W(HIST_W)
) u_mvbp_checker (.*);

// File: tb/tb_mvbp_predictor.sv
module tb_mvbp_predictor;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W = 32;

    // Instance A: defaults (3-bit history, 16 entries, word aligned).
    localparam int A_IDX = 4, A_AL = 2, A_LN = 0, A_H = 3;
    // Instance B: 4-bit history, 8 entries, two words per line.
    localparam int B_IDX = 3, B_AL = 2, B_LN = 1, B_H = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [PC_W-1:0] lk_pc = '0;
    logic [PC_W-1:0] up_pc = '0;
    logic up_valid = 1'b0;
    logic up_taken = 1'b0;
    logic a_taken, b_taken;
    logic [A_H-1:0] a_hist;
    logic [B_H-1:0] b_hist;

    always #(CLK_PERIOD/2) clk = ~clk;

    mvbp_predictor dut (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(a_taken), .lk_hist(a_hist),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
    );

    mvbp_predictor #(
        .PC_W(PC_W), .IDX_W(B_IDX), .ALIGN_W(B_AL), .LINE_W(B_LN), .HIST_W(B_H)
    ) dut_b (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(b_taken), .lk_hist(b_hist),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // Reference state, built from the requirements.
    logic [A_H-1:0] mod_a [1 << A_IDX];
    logic [B_H-1:0] mod_b [1 << B_IDX];

    typedef struct {
        logic           ta;
        logic [A_H-1:0] ha;
        logic           tb;
        logic [B_H-1:0] hb;
        string          tag;
    } exp_t;

    exp_t sb_q[$];
    event sample_ev;

    function automatic int idx_a(logic [PC_W-1:0] pc);
        return int'((pc >> (A_AL + A_LN)) & ((1 << A_IDX) - 1));
    endfunction

    function automatic int idx_b(logic [PC_W-1:0] pc);
        return int'((pc >> (B_AL + B_LN)) & ((1 << B_IDX) - 1));
    endfunction

    function automatic logic vote(int ones, int width);
        return (2 * ones) > width;
    endfunction

    // Driver: apply one cycle of stimulus, push expected lookup result.
    task automatic step(input logic [PC_W-1:0] lpc, input logic uv,
                        input logic [PC_W-1:0] upc, input logic ut, input string tag);
        exp_t e;
        @(negedge clk);
        lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut;
        #(CLK_PERIOD/4);
        e.ha = mod_a[idx_a(lpc)];
        e.hb = mod_b[idx_b(lpc)];
        e.ta = vote($countones(e.ha), A_H);
        e.tb = vote($countones(e.hb), B_H);
        e.tag = tag;
        sb_q.push_back(e);
        -> sample_ev;
        #1;
        if (uv) begin
            mod_a[idx_a(upc)] = {mod_a[idx_a(upc)][A_H-2:0], ut};
            mod_b[idx_b(upc)] = {mod_b[idx_b(upc)][B_H-2:0], ut};
        end
    endtask

    task automatic check(input string tag, input string what, input logic [7:0] act,
                         input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: pop expected items and compare with the design outputs.
    initial begin
        forever begin
            @(sample_ev);
            if (sb_q.size() != 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, "a_hist",  8'(a_hist),  8'(e.ha));
                check(e.tag, "a_taken", 8'(a_taken), 8'(e.ta));
                check(e.tag, "b_hist",  8'(b_hist),  8'(e.hb));
                check(e.tag, "b_taken", 8'(b_taken), 8'(e.tb));
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < (1 << A_IDX); i++) mod_a[i] = '0;
        for (int i = 0; i < (1 << B_IDX); i++) mod_b[i] = '0;
        // Garbage on update inputs during reset must not survive it.
        up_valid = 1'b1; up_taken = 1'b1; up_pc = 32'h40;
        repeat (4) @(negedge clk);
        rst = 1'b0; up_valid = 1'b0;

        // R1: cleared table, several PCs.
        step(32'h0000_0000, 1'b0, '0, 1'b0, "R1");
        step(32'h0000_0040, 1'b0, '0, 1'b0, "R1");
        step(32'hFFFF_FFFC, 1'b0, '0, 1'b0, "R1");

        // R9: lookup and update to the same entry in one cycle.
        step(32'h40, 1'b1, 32'h40, 1'b1, "R9_same_cycle");
        // R6/R2/R3: history 001, then 011 with further updates.
        step(32'h40, 1'b1, 32'h40, 1'b1, "R6_one_taken");
        // R4: 011 predicts taken.
        step(32'h40, 1'b1, 32'h40, 1'b0, "R4_two_of_three");
        // R4: 110 still taken.
        step(32'h40, 1'b1, 32'h40, 1'b0, "R4_110");
        // R6: 100, oldest bit dropped next.
        step(32'h40, 1'b1, 32'h40, 1'b0, "R6_drop_oldest");
        step(32'h40, 1'b0, 32'h40, 1'b1, "R6_all_clear");

        // R10: update lines driven but not qualified.
        step(32'h40, 1'b0, 32'h40, 1'b1, "R10_idle");
        step(32'h40, 1'b0, 32'h40, 1'b1, "R10_idle");
        step(32'h40, 1'b0, 32'h40, 1'b0, "R10_after");

        // R7: low alignment bits and high bits ignored (aliasing).
        step(32'h44, 1'b1, 32'h47, 1'b1, "R7_low_bits");
        step(32'h44, 1'b1, 32'h8000_0044, 1'b1, "R7_high_bits");
        step(32'h45, 1'b1, 32'h44, 1'b1, "R7_alias_read");
        step(32'h1_0044, 1'b0, '0, 1'b0, "R7_alias_read");

        // R8/R5: line sharing in B, tie with 4 bits.
        step(32'h80, 1'b1, 32'h84, 1'b1, "R8_line_share");
        step(32'h80, 1'b1, 32'h80, 1'b1, "R8_line_share");
        step(32'h84, 1'b1, 32'h84, 1'b0, "R5_tie");
        step(32'h80, 1'b1, 32'h84, 1'b0, "R5_tie");
        step(32'h84, 1'b0, '0, 1'b0, "R5_tie");

        // Mixed traffic across many entries.
        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            logic [PC_W-1:0] a, u;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = {24'h0, lfsr[7:0]};
            u = {24'h0, lfsr[5:0], lfsr[9:8]};
            step(a, lfsr[11], u, lfsr[14], "R6_mixed");
        end

        // R1: reset again clears learned state.
        @(negedge clk); rst = 1'b1; up_valid = 1'b0;
        @(negedge clk);
        for (int i = 0; i < (1 << A_IDX); i++) mod_a[i] = '0;
        for (int i = 0; i < (1 << B_IDX); i++) mod_b[i] = '0;
        rst = 1'b0;
        step(32'h40, 1'b0, '0, 1'b0, "R1_rereset");
        step(32'h44, 1'b0, '0, 1'b0, "R1_rereset");

        @(negedge clk);
        finish_run();
    end

endmodule